// File: doc/BRIEF.md
# Synchronous Burst Memory with Dual Address Strobes

This block is an on-chip single-clock memory that answers to the control interface of a pipelined burst static RAM. The default build holds 2K words. Each word has four 9-bit byte lanes, 36 bits in all. The depth is a parameter. Every control input, the address and the write data are captured on the rising clock edge. The access those captured values describe is carried out against the array on the following edge. Read data therefore leaves the block one clock after its access was captured.

There are two address strobes. The processor strobe loads a new address and always reads. The controller strobe loads a new address and either reads or writes, as the write controls select. When the chip selects are not all asserted, the controller strobe deselects the memory instead. A word is written in one of two ways: a global write stores all four lanes, or a per-lane write is gated by a common lane-write enable. A 2-bit burst counter supplies the two low address bits. It follows linear or interleaved order and can hold still for wait cycles. An output enable and a sleep input gate the read bus, and sleep also blocks every access.

The controller has four named states. `ST_IDLE` means no burst is open. `ST_READ` and `ST_WRITE` mean a burst is open, and the last captured access was a read or a write. `ST_SLEEP` means the sleep input was high at the last edge. The transitions are as follows. A sleep edge goes from any state to `ST_SLEEP`. A processor start goes from any other state to `ST_READ`. A selected controller start goes to `ST_READ` or `ST_WRITE`, by the write controls. A deselecting controller strobe goes from any other state to `ST_IDLE`. A continuation cycle with no strobe goes from `ST_READ`/`ST_WRITE` to `ST_READ` or `ST_WRITE`, by the write controls. In `ST_IDLE` or `ST_SLEEP`, a cycle with no valid strobe leads to `ST_IDLE`.

Top module: `sburst_ram`

## Requirements
- R1: After reset, and until a read access completes, `rdata_vld` is 0 and `rdata` is all zeros.
- R2: With `strobe_cpu_n` low and `cs1_n` low at an edge, the address is loaded and a read of that word happens, even if `gwr_n` or the lane-write controls ask for a write. With `cs1_n` high, `strobe_cpu_n` has no effect: from `ST_IDLE` no access occurs and `rdata_vld` stays 0.
- R3: With `strobe_ctl_n` low and no processor start, the memory is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. In that case the address is loaded. Otherwise the block enters `ST_IDLE`, performs no access, and `rdata_vld` is 0 one clock later.
- R4: When both strobes are low and `cs1_n` is low, the processor strobe wins. The cycle reads, and the word is left unchanged even if a global write is requested.
- R5: `gwr_n` low on a write access stores all 36 bits, whatever `lane_wr_en_n` and `lane_wr_n` hold. A write access gives `rdata_vld`=0 one clock later.
- R6: With `gwr_n` high and `lane_wr_en_n` low, lane i (bits 9i+8 down to 9i) is written exactly when `lane_wr_n[i]` is 0. With `lane_wr_en_n` high and `gwr_n` high, the access is a read.
- R7: With `burst_ilv`=0, the low two address bits of beat n (n = 0..3 advances) are (loaded low bits + n) mod 4.
- R8: With `burst_ilv`=1, the low two address bits of beat n are (loaded low bits) XOR n.
- R9: In `ST_READ`/`ST_WRITE` with no strobe, `burst_adv_n` low advances the counter by one beat. `burst_adv_n` high repeats the previous address.
- R10: A read access captured at edge k places the word on `rdata` with `rdata_vld`=1 after edge k+1.
- R11: `out_en_n` high forces `rdata_vld` to 0 and `rdata` to zero at once, without a clock. Lowering it restores the held read word.
- R12: While `sleep` is high, `rdata` is zero and `rdata_vld` is 0. An access presented at an edge with `sleep` high does not change the array.
- R13: In `ST_IDLE` a cycle with no valid strobe performs no access, even with `burst_adv_n` and `gwr_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, low two bits seed the burst counter |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, read-only start |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low; high means wait cycle |
| cs1_n | input | 1 | Chip select, active low, also qualifies the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enable for per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write, active low, bit i for lane i |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| out_en_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Standby, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
Full-word write bursts followed by processor read bursts are run for every starting low address in both burst orders. Each beat returns the pattern of its own address, so a wrong counter order shows up as the data of a neighbouring word. Wait-cycle reads are checked against advancing reads, to tell a held counter from a stepping one. Lane-masked writes, followed by reads both with and without the lane enable, separate the per-lane write from the global write and from a plain read. Strobe collisions, deselects, idle continuations and sleep are each followed by a read-back of a known word, which exposes any unwanted write.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Controller states of the burst memory
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sbr_state_e;

    // Width of the in-row burst counter
    localparam int BEAT_W = 2;

endpackage

// File: rtl/sbr_burst.sv
module sbr_burst
    import sbr_pkg::*;
(
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] cnt,
    input  logic              ilv,
    output logic [BEAT_W-1:0] lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear order wraps inside the row; interleaved flips bits of the seed
    always_comb begin
        lin_lo = base + cnt;
        ilv_lo = base ^ cnt;
        lo     = ilv ? ilv_lo : lin_lo;
    end

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    burst_adv_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    gwr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    acc_vld,
    output logic [LANES-1:0]        acc_wmask,
    output logic [ADDR_W-1:0]       acc_addr,
    output logic [LANES*LANE_W-1:0] acc_wdata
);

    localparam int HI_W   = ADDR_W - BEAT_W;
    localparam int DATA_W = LANES * LANE_W;

    sbr_state_e st_q, st_d;

    logic              sel, cpu_go, ctl_go, desel_go, cont_go, burst_open;
    logic              load, cont, is_wr, vld_d;
    logic [LANES-1:0]  wmask_in, wmask_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic [BEAT_W-1:0] base_q, base_d, cnt_q, cnt_d, lo_d;

    // Strobe decode with processor priority
    always_comb begin
        sel        = !cs1_n && cs2 && !cs3_n;
        cpu_go     = !strobe_cpu_n && !cs1_n;
        ctl_go     = !strobe_ctl_n && !cpu_go && sel;
        desel_go   = !strobe_ctl_n && !cpu_go && !sel;
        burst_open = (st_q == ST_READ) || (st_q == ST_WRITE);
        cont_go    = strobe_ctl_n && !cpu_go && burst_open;
        if (!gwr_n) begin
            wmask_in = '1;
        end else if (!lane_wr_en_n) begin
            wmask_in = ~lane_wr_n;
        end else begin
            wmask_in = '0;
        end
        is_wr = |wmask_in;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d = ST_SLEEP;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SLEEP: begin
                    if (cpu_go)      st_d = ST_READ;
                    else if (ctl_go) st_d = is_wr ? ST_WRITE : ST_READ;
                    else             st_d = ST_IDLE;
                end
                ST_READ, ST_WRITE: begin
                    if (cpu_go)        st_d = ST_READ;
                    else if (ctl_go)   st_d = is_wr ? ST_WRITE : ST_READ;
                    else if (desel_go) st_d = ST_IDLE;
                    else               st_d = is_wr ? ST_WRITE : ST_READ;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    sbr_burst u_burst (
        .base (base_d),
        .cnt  (cnt_d),
        .ilv  (burst_ilv),
        .lo   (lo_d)
    );

    // Output and address logic
    always_comb begin
        load   = !sleep && (cpu_go || ctl_go);
        cont   = !sleep && cont_go;
        hi_d   = hi_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load) begin
            hi_d   = addr[ADDR_W-1:BEAT_W];
            base_d = addr[BEAT_W-1:0];
            cnt_d  = '0;
        end else if (cont && !burst_adv_n) begin
            cnt_d = cnt_q + 1'b1;
        end
        vld_d   = load || cont;
        wmask_d = (cpu_go || !vld_d) ? '0 : wmask_in;
    end

    // Counter and captured-access registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            base_q    <= '0;
            cnt_q     <= '0;
            acc_vld   <= 1'b0;
            acc_wmask <= '0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else begin
            hi_q      <= hi_d;
            base_q    <= base_d;
            cnt_q     <= cnt_d;
            acc_vld   <= vld_d;
            acc_wmask <= wmask_d;
            acc_addr  <= {hi_d, lo_d};
            acc_wdata <= wdata[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_vld,
    input  logic [LANES-1:0]        acc_wmask,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] acc_wdata,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    logic do_rd;

    always_comb begin
        do_rd = acc_vld && (acc_wmask == '0) && !sleep;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (acc_vld && acc_wmask[g] && !sleep) begin
                mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
            end
            if (do_rd) begin
                rd_q <= mem[acc_addr];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= do_rd;
        end
    end

endmodule

// File: rtl/sburst_ram.sv
module sburst_ram #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    burst_adv_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    gwr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld
);

    localparam int DATA_W = LANES * LANE_W;

    logic              acc_vld;
    logic [LANES-1:0]  acc_wmask;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;
    logic              drive;

    sbr_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .burst_adv_n  (burst_adv_n),
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .gwr_n        (gwr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .burst_ilv    (burst_ilv),
        .sleep        (sleep),
        .wdata        (wdata),
        .acc_vld      (acc_vld),
        .acc_wmask    (acc_wmask),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata)
    );

    sbr_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vld   (acc_vld),
        .acc_wmask (acc_wmask),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .sleep     (sleep),
        .rd_data   (rd_data),
        .rd_vld    (rd_vld)
    );

    // Output gating by enable and standby, no clock involved
    always_comb begin
        drive     = rd_vld && !out_en_n && !sleep;
        rdata_vld = drive;
        rdata     = drive ? rd_data : '0;
    end

endmodule

// File: rtl/sbr_checks.sv
module sbr_checks #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              gwr_n,
    input logic              out_en_n,
    input logic              sleep,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld
);

    logic sel_all;
    assign sel_all = !cs1_n && cs2 && !cs3_n;

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!rdata_vld && rdata == '0)); // R11

    AST_SLEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rdata_vld && rdata == '0)); // R12

    AST_CPU_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !cs1_n && !sleep) ##1 !sleep
        |=> (out_en_n || sleep || rdata_vld)); // R10

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && (strobe_cpu_n || cs1_n) && !sel_all && !sleep)
        |=> ##1 !rdata_vld); // R3

    AST_GW_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && strobe_cpu_n && sel_all && !gwr_n && !sleep)
        |=> ##1 !rdata_vld); // R5

    AST_CPU_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !strobe_ctl_n && sel_all && !gwr_n && !sleep) ##1 !sleep
        |=> (out_en_n || sleep || rdata_vld)); // R4

endmodule

bind sburst_ram sbr_checks #(
    .DATA_W (LANES * LANE_W)
) u_sbr_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .cs1_n        (cs1_n),
    .cs2          (cs2),
    .cs3_n        (cs3_n),
    .gwr_n        (gwr_n),
    .out_en_n     (out_en_n),
    .sleep        (sleep),
    .rdata        (rdata),
    .rdata_vld    (rdata_vld)
);

// File: tb/tb_sburst_ram.sv
`timescale 1ns/1ps
module tb_sburst_ram;

    localparam int AW = 11;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          gwr_n = 1'b1, len_n = 1'b1;
    logic [NL-1:0] lwr_n = '1;
    logic          ilv = 1'b0, oe_n = 1'b0, slp = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Pending expectation: captured access of the previous tick
    bit            pend = 0, nxt_pend = 0;
    logic          exp_vld, nxt_vld;
    logic [DW-1:0] exp_data, nxt_data;
    string         exp_tag, nxt_tag;

    always #2 clk = ~clk;

    sburst_ram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk (clk), .rst_n (rst_n), .addr (addr),
        .strobe_cpu_n (cpu_n), .strobe_ctl_n (ctl_n), .burst_adv_n (adv_n),
        .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n),
        .gwr_n (gwr_n), .lane_wr_en_n (len_n), .lane_wr_n (lwr_n),
        .burst_ilv (ilv), .out_en_n (oe_n), .sleep (slp),
        .wdata (wdata), .rdata (rdata), .rdata_vld (rdata_vld)
    );

    function automatic logic [DW-1:0] pat(input int a);
        logic [DW-1:0] p;
        p = DW'(a);
        return (p * 36'd40503) ^ 36'h9A5C31E7B;
    endfunction

    function automatic int beat(input int s, input int n, input bit mode);
        return mode ? (s ^ n) : ((s + n) % 4);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_out(input logic v, input logic [DW-1:0] d, input string tag);
        check((rdata_vld === v) && (rdata === d), tag, {rdata_vld, rdata}, {v, d});
    endtask

    task automatic expect_rd(input logic [DW-1:0] d, input string tag);
        nxt_pend = 1; nxt_vld = 1'b1; nxt_data = d; nxt_tag = tag;
    endtask

    task automatic expect_none(input string tag);
        nxt_pend = 1; nxt_vld = 1'b0; nxt_data = '0; nxt_tag = tag;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (pend) check_out(exp_vld, exp_data, exp_tag);
        pend = nxt_pend; exp_vld = nxt_vld; exp_data = nxt_data; exp_tag = nxt_tag;
        nxt_pend = 0;
    endtask

    task automatic quiet();
        cpu_n = 1; ctl_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
        gwr_n = 1; len_n = 1; lwr_n = '1;
    endtask

    task automatic desel();
        quiet(); ctl_n = 0; cs2 = 0;
        expect_none("R3 deselect");
        tick();
    endtask

    task automatic wr_burst(input int row, input int s, input bit mode);
        quiet(); ilv = mode;
        addr = AW'(row * 4 + s); ctl_n = 0; gwr_n = 0; lwr_n = 4'b0101;
        wdata = pat(row * 4 + s);
        expect_none("R5 write");
        tick();
        for (int n = 1; n < 4; n++) begin
            quiet(); adv_n = 0; gwr_n = 0;
            wdata = pat(row * 4 + beat(s, n, mode));
            expect_none("R5 write beat");
            tick();
        end
        desel();
    endtask

    task automatic rd_burst(input int row, input int s, input bit mode);
        string tg;
        tg = mode ? "R8 interleaved" : "R7 linear";
        quiet(); ilv = mode;
        addr = AW'(row * 4 + s); cpu_n = 0; gwr_n = 0;  // R2: write request ignored
        expect_rd(pat(row * 4 + s), "R2 R10 first beat");
        tick();
        for (int n = 1; n < 4; n++) begin
            quiet(); adv_n = 0;
            expect_rd(pat(row * 4 + beat(s, n, mode)), tg);
            tick();
        end
        desel();
    endtask

    initial begin
        logic [DW-1:0] masked;
        quiet();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check_out(1'b0, '0, "R1 reset");
        tick();
        check_out(1'b0, '0, "R1 after release");

        // Exhaustive start position x burst order
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                wr_burst(8 + m * 4 + s, s, m[0]);
                rd_burst(8 + m * 4 + s, s, m[0]);
            end
        end

        // R9: wait cycles hold the address
        wr_burst(3, 0, 1'b0);
        quiet(); ilv = 0; addr = AW'(13); ctl_n = 0;
        expect_rd(pat(13), "R9 load"); tick();
        quiet(); adv_n = 1; expect_rd(pat(13), "R9 wait"); tick();
        quiet(); adv_n = 0; expect_rd(pat(14), "R9 advance"); tick();
        quiet(); adv_n = 1; expect_rd(pat(14), "R9 wait again"); tick();
        desel();

        // R6: lane writes, lanes 0 and 2 cleared
        masked = pat(12) & ~((DW'(9'h1FF)) | (DW'(9'h1FF) << 18));
        quiet(); addr = AW'(12); ctl_n = 0; len_n = 0; lwr_n = 4'b1010; wdata = '0;
        expect_none("R6 lane write"); tick();
        desel();
        quiet(); addr = AW'(12); ctl_n = 0; len_n = 1; lwr_n = 4'b0000;
        expect_rd(masked, "R6 merged lanes, disabled lane enable reads"); tick();
        desel();
        quiet(); addr = AW'(12); cpu_n = 0;
        expect_rd(masked, "R6 unchanged after gated read"); tick();
        desel();

        // R2: processor strobe ignored without cs1_n
        quiet(); cpu_n = 0; cs1_n = 1; expect_none("R2 ignored"); tick();
        // R13: idle continuation has no effect
        quiet(); adv_n = 0; gwr_n = 0; wdata = '0; expect_none("R13 idle"); tick();
        quiet(); adv_n = 0; gwr_n = 0; wdata = '0; expect_none("R13 idle"); tick();
        // R3: deselect through cs1_n and cs3_n
        quiet(); ctl_n = 0; cs1_n = 1; expect_none("R3 cs1 off"); tick();
        quiet(); ctl_n = 0; cs3_n = 1; gwr_n = 0; expect_none("R3 cs3 off"); tick();
        quiet(); addr = AW'(12); cpu_n = 0;
        expect_rd(masked, "R13 R3 word intact"); tick();
        desel();

        // R4: processor strobe beats controller strobe
        quiet(); addr = AW'(12); cpu_n = 0; ctl_n = 0; gwr_n = 0; wdata = '1;
        expect_rd(masked, "R4 priority read"); tick();
        desel();
        quiet(); addr = AW'(12); cpu_n = 0;
        expect_rd(masked, "R4 no write"); tick();
        desel();

        // R11 and R12: combinational gating
        quiet(); addr = AW'(13); cpu_n = 0;
        expect_rd(pat(13), "R10 read"); tick();
        desel();
        oe_n = 1; #1 check_out(1'b0, '0, "R11 disabled");
        oe_n = 0; #1 check_out(1'b1, pat(13), "R11 restored");
        slp = 1;
        #0.5 check_out(1'b0, '0, "R12 sleep zero");
        quiet(); addr = AW'(14); ctl_n = 0; gwr_n = 0; wdata = '0;
        expect_none("R12 write in sleep"); tick();
        quiet(); expect_none("R12 sleep"); tick();
        slp = 0;
        desel();
        quiet(); addr = AW'(14); cpu_n = 0;
        expect_rd(pat(14), "R12 array untouched"); tick();
        desel();
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule